// File: doc/BRIEF.md
# Policy-Selectable Data Cache

This block is a small direct-mapped data cache that sits between a CPU-side request port and a word-wide memory port with a valid/ready handshake. Every request carries its own write policy and a cacheable flag, which the protection logic derives from the memory attributes of the address. The policy can be write-through without write allocation, write-back without write allocation, or write-back with write allocation. Only normal, non-shared memory is marked cacheable. Device, strongly ordered and shared accesses are sent to memory one word at a time and never touch the cache.

The CPU keeps a request steady until `req_ready` is high. That cycle completes the access, and for a read `rsp_rdata` carries the data in the same cycle. A hit that needs no memory traffic completes in the cycle it is presented. Any access that involves the memory port stalls the CPU until the memory work is done: a line fill, a dirty-line eviction, a write-through word, or a bypass word. A one-cycle `inv_all` pulse discards every line at once.

Top module: `pdc_cache`

## Requirements
- R1: The address decodes as tag = bits [31:8], line index = bits [7:4] and word offset = bits [3:2], which gives 16 direct-mapped lines of four 32-bit words. The policy code is 2'b00 for write-through with no write allocation, 2'b01 for write-back with no write allocation, and 2'b10 or 2'b11 for write-back with write allocation.
- R2: A cacheable read that hits completes in the cycle it is presented. It returns the cached word and causes no memory traffic.
- R3: A cacheable read that misses fills the whole line with four memory reads, at offsets 0 to 3, and then returns the requested word.
- R4: A write hit under write-through sends exactly one word write to memory and also updates the cached word.
- R5: A write hit under either write-back policy updates the cached word, marks the line dirty and causes no memory traffic.
- R6: When a miss allocates into a line that holds dirty data, the four victim words are written to the victim's own addresses before the fill reads begin.
- R7: A write miss without write allocation sends one word write to memory and leaves the cache unchanged, so a later cacheable read of that line still misses.
- R8: A write miss with write allocation fills the line, merges the write data and marks the line dirty. Memory is not written until that line is evicted.
- R9: A non-cacheable access makes exactly one memory transfer. It does no lookup and no allocation, and it does not update a cached copy of the same address.
- R10: A one-cycle `inv_all` pulse clears every valid and dirty bit and writes nothing back. A request presented in that same cycle waits.
- R11: `req_ready` stays low whenever the memory port has a transfer outstanding. A memory request holds its address and direction until `mem_ready` accepts it.
- R12: Coming out of reset, no line is valid, `mem_valid` is low and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | One-cycle pulse that discards all lines |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_policy | input | 2 | Write/allocate policy code |
| req_cacheable | input | 1 | Normal non-shared memory |
| req_ready | output | 1 | Access completes this cycle |
| rsp_rdata | output | 32 | Read data, valid when req_ready is high |
| mem_valid | output | 1 | Memory transfer request |
| mem_write | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the transfer this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |

## Verification
The bench runs a stream of accesses against a memory model that accepts a transfer only every other cycle. For each access it counts the memory writes and reads, so that clean fills, dirty evictions, write-through words and bypass words can be told apart by their beat counts. The stream covers every policy code against hits, misses on clean lines and misses on dirty lines. Non-cacheable reads of the same addresses then show what actually reached memory, which separates write-back data that stayed in the cache from data that was forwarded or evicted. Further directed accesses check the reset state, single-cycle hit latency, the no-allocate outcome of bypass reads and plain write misses, and an invalidate that drops a dirty line without a write-back.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [1:0] {
    POL_WT   = 2'b00,
    POL_WB   = 2'b01,
    POL_WBA  = 2'b10,
    POL_WBA2 = 2'b11
  } pol_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_MWR,
    ST_MRD,
    ST_DONE
  } st_e;

endpackage

// File: rtl/pdc_tag_store.sv
module pdc_tag_store #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned LINES = 16,
  parameter int unsigned WORDS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inv_all,
  input  logic [$clog2(LINES)-1:0] idx,
  input  logic [$clog2(WORDS)-1:0] rd_off,
  input  logic                 wr_en,
  input  logic [$clog2(WORDS)-1:0] wr_off,
  input  logic [DW-1:0]        wr_data,
  input  logic                 set_dirty,
  input  logic                 install,
  input  logic [AW-$clog2(LINES)-$clog2(WORDS)-$clog2(DW/8)-1:0] inst_tag,
  output logic [DW-1:0]        rd_data,
  output logic [AW-$clog2(LINES)-$clog2(WORDS)-$clog2(DW/8)-1:0] rd_tag,
  output logic                 rd_valid,
  output logic                 rd_dirty
);

  localparam int unsigned IDX_W  = $clog2(LINES);
  localparam int unsigned OFF_W  = $clog2(WORDS);
  localparam int unsigned BYTE_W = $clog2(DW/8);
  localparam int unsigned TAG_W  = AW - IDX_W - OFF_W - BYTE_W;

  logic [LINES-1:0] valid_q, valid_d;
  logic [LINES-1:0] dirty_q, dirty_d;
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [DW-1:0]    data_q [LINES][WORDS];

  // Line state next-state: invalidate wins over install and dirty marking
  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (inv_all) begin
      valid_d = '0;
      dirty_d = '0;
    end else if (install) begin
      valid_d[idx] = 1'b1;
      dirty_d[idx] = 1'b0;
    end else if (set_dirty) begin
      dirty_d[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  // Storage arrays carry no reset; enables written out
  always_ff @(posedge clk) begin
    if (install) tag_q[idx] <= inst_tag;
    if (wr_en)   data_q[idx][wr_off] <= wr_data;
  end

  assign rd_data  = data_q[idx][rd_off];
  assign rd_tag   = tag_q[idx];
  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];

  // R10: an invalidate pulse leaves no valid or dirty line behind
  a_r10_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0) && (dirty_q == '0));

  // R5: dirty marking is only ever applied to a resident line
  a_r5_dirty_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_q & ~valid_q) == '0);

endmodule

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned LINES = 16,
  parameter int unsigned WORDS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inv_all,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  input  logic [1:0]           req_policy,
  input  logic                 req_cacheable,
  output logic                 req_ready,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 mem_valid,
  output logic                 mem_write,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  input  logic                 mem_ready,
  input  logic [DW-1:0]        mem_rdata,
  // store side
  output logic [$clog2(LINES)-1:0] st_idx,
  output logic [$clog2(WORDS)-1:0] st_rd_off,
  output logic                 st_wr_en,
  output logic [$clog2(WORDS)-1:0] st_wr_off,
  output logic [DW-1:0]        st_wr_data,
  output logic                 st_set_dirty,
  output logic                 st_install,
  output logic [AW-$clog2(LINES)-$clog2(WORDS)-$clog2(DW/8)-1:0] st_tag,
  input  logic [DW-1:0]        line_word,
  input  logic [AW-$clog2(LINES)-$clog2(WORDS)-$clog2(DW/8)-1:0] line_tag,
  input  logic                 line_valid,
  input  logic                 line_dirty
);

  localparam int unsigned IDX_W  = $clog2(LINES);
  localparam int unsigned OFF_W  = $clog2(WORDS);
  localparam int unsigned BYTE_W = $clog2(DW/8);
  localparam int unsigned TAG_W  = AW - IDX_W - OFF_W - BYTE_W;
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

  st_e              state_q, state_d;
  logic [OFF_W-1:0] beat_q, beat_d;
  logic [DW-1:0]    cap_q, cap_d;

  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic [OFF_W-1:0] req_off;
  logic             hit, pol_wt, pol_alloc;

  assign req_tag   = req_addr[AW-1 -: TAG_W];
  assign req_idx   = req_addr[BYTE_W+OFF_W +: IDX_W];
  assign req_off   = req_addr[BYTE_W +: OFF_W];
  assign hit       = line_valid && (line_tag == req_tag);
  assign pol_wt    = (req_policy == POL_WT);
  assign pol_alloc = req_policy[1];

  assign st_idx = req_idx;
  assign st_tag = req_tag;

  always_comb begin
    state_d      = state_q;
    beat_d       = beat_q;
    cap_d        = cap_q;
    req_ready    = 1'b0;
    rsp_rdata    = line_word;
    mem_valid    = 1'b0;
    mem_write    = 1'b0;
    mem_addr     = req_addr;
    mem_wdata    = req_wdata;
    st_rd_off    = req_off;
    st_wr_en     = 1'b0;
    st_wr_off    = req_off;
    st_wr_data   = req_wdata;
    st_set_dirty = 1'b0;
    st_install   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && !inv_all) begin
          if (!req_cacheable) begin
            state_d = req_write ? ST_MWR : ST_MRD;
          end else if (hit) begin
            if (!req_write) begin
              req_ready = 1'b1;
            end else if (pol_wt) begin
              state_d = ST_MWR;
            end else begin
              req_ready    = 1'b1;
              st_wr_en     = 1'b1;
              st_set_dirty = 1'b1;
            end
          end else if (!req_write || pol_alloc) begin
            beat_d  = '0;
            state_d = line_dirty ? ST_EVICT : ST_FILL;
          end else begin
            state_d = ST_MWR;
          end
        end
      end
      ST_EVICT: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        st_rd_off = beat_q;
        mem_addr  = {line_tag, req_idx, beat_q, {BYTE_W{1'b0}}};
        mem_wdata = line_word;
        if (mem_ready) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_valid = 1'b1;
        mem_addr  = {req_tag, req_idx, beat_q, {BYTE_W{1'b0}}};
        if (mem_ready) begin
          st_wr_en   = 1'b1;
          st_wr_off  = beat_q;
          st_wr_data = mem_rdata;
          beat_d     = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) begin
            st_install = 1'b1;
            state_d    = ST_IDLE;
          end
        end
      end
      ST_MWR: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        if (mem_ready) begin
          st_wr_en = req_cacheable && hit;
          state_d  = ST_DONE;
        end
      end
      ST_MRD: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          cap_d   = mem_rdata;
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        req_ready = 1'b1;
        rsp_rdata = cap_q;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      cap_q   <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      cap_q   <= cap_d;
    end
  end

  // R11: CPU sees no completion while the memory port is busy
  a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  // R11: an unaccepted memory request is held unchanged
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

  // R6: the last accepted eviction word is followed by the fill
  a_r6_evict_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVICT && mem_ready && beat_q == LAST_BEAT) |=> (mem_valid && !mem_write));

  // R9: a non-cacheable request never allocates or dirties a line
  a_r9_bypass_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_cacheable) |-> (!st_install && !st_set_dirty));

endmodule

// File: rtl/pdc_cache.sv
module pdc_cache #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned LINES = 16,
  parameter int unsigned WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inv_all,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_policy,
  input  logic          req_cacheable,
  output logic          req_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata
);

  localparam int unsigned IDX_W  = $clog2(LINES);
  localparam int unsigned OFF_W  = $clog2(WORDS);
  localparam int unsigned BYTE_W = $clog2(DW/8);
  localparam int unsigned TAG_W  = AW - IDX_W - OFF_W - BYTE_W;

  // Asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [IDX_W-1:0] st_idx;
  logic [OFF_W-1:0] st_rd_off, st_wr_off;
  logic             st_wr_en, st_set_dirty, st_install;
  logic [DW-1:0]    st_wr_data, line_word;
  logic [TAG_W-1:0] st_tag, line_tag;
  logic             line_valid, line_dirty;

  pdc_tag_store #(.AW(AW), .DW(DW), .LINES(LINES), .WORDS(WORDS)) store_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .inv_all   (inv_all),
    .idx       (st_idx),
    .rd_off    (st_rd_off),
    .wr_en     (st_wr_en),
    .wr_off    (st_wr_off),
    .wr_data   (st_wr_data),
    .set_dirty (st_set_dirty),
    .install   (st_install),
    .inst_tag  (st_tag),
    .rd_data   (line_word),
    .rd_tag    (line_tag),
    .rd_valid  (line_valid),
    .rd_dirty  (line_dirty)
  );

  pdc_ctrl #(.AW(AW), .DW(DW), .LINES(LINES), .WORDS(WORDS)) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .inv_all       (inv_all),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .req_policy    (req_policy),
    .req_cacheable (req_cacheable),
    .req_ready     (req_ready),
    .rsp_rdata     (rsp_rdata),
    .mem_valid     (mem_valid),
    .mem_write     (mem_write),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ready     (mem_ready),
    .mem_rdata     (mem_rdata),
    .st_idx        (st_idx),
    .st_rd_off     (st_rd_off),
    .st_wr_en      (st_wr_en),
    .st_wr_off     (st_wr_off),
    .st_wr_data    (st_wr_data),
    .st_set_dirty  (st_set_dirty),
    .st_install    (st_install),
    .st_tag        (st_tag),
    .line_word     (line_word),
    .line_tag      (line_tag),
    .line_valid    (line_valid),
    .line_dirty    (line_dirty)
  );

  // R12: no memory request while the internal reset is held
  a_r12_quiet_in_reset: assert property (@(posedge clk)
    !rst_int_n |-> !mem_valid);

endmodule

// File: tb/pdc_cache_tb_top.sv
module pdc_cache_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        inv_all;
  logic        req_valid, req_write, req_cacheable;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_policy;
  logic        req_ready;
  logic [31:0] rsp_rdata;
  logic        mem_valid, mem_write, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  pdc_cache dut_i (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_policy(req_policy), .req_cacheable(req_cacheable),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  // Memory model: 256 words, accepts on every other cycle
  logic [31:0] mem [256];
  logic        gate;
  always @(posedge clk) begin
    if (!rst_n) begin
      gate <= 1'b0;
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA000_0000 + 32'(i);
    end else begin
      gate <= ~gate;
      if (mem_valid && mem_ready && mem_write) mem[mem_addr[9:2]] <= mem_wdata;
    end
  end
  assign mem_ready = mem_valid & gate;
  assign mem_rdata = mem[mem_addr[9:2]];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One CPU access; returns data, memory beats seen and cycles taken
  task automatic access(input bit w, input logic [31:0] a, input logic [31:0] d,
                        input logic [1:0] pol, input bit cach,
                        output logic [31:0] rd, output int nwr, output int nrd, output int ncyc);
    bit done = 1'b0;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    req_policy = pol; req_cacheable = cach;
    nwr = 0; nrd = 0; ncyc = 0; rd = '0;
    while (!done && ncyc < 200) begin
      #2;
      ncyc++;
      if (mem_valid && mem_ready) begin
        if (mem_write) nwr++; else nrd++;
      end
      if (req_ready) begin
        done = 1'b1;
        rd = rsp_rdata;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (!done) chk(1'b0, "R11 access hung", 32'(ncyc), 32'd200);
  endtask

  typedef struct packed {
    logic        w;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [1:0]  pol;
    logic        cach;
    logic [31:0] exp;
    logic [3:0]  nwr;
    logic [3:0]  nrd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h010, 32'h0,        2'd1, 1'b1, 32'hA000_0004, 4'd0, 4'd4, 4'd3},  // R3 clean fill
    '{1'b0, 12'h014, 32'h0,        2'd1, 1'b1, 32'hA000_0005, 4'd0, 4'd0, 4'd2},  // R2 hit
    '{1'b1, 12'h018, 32'h1111_1111, 2'd0, 1'b1, 32'h0,        4'd1, 4'd0, 4'd4},  // R4 WT hit
    '{1'b0, 12'h018, 32'h0,        2'd1, 1'b1, 32'h1111_1111, 4'd0, 4'd0, 4'd4},  // R4 line updated
    '{1'b1, 12'h01C, 32'h2222_2222, 2'd1, 1'b1, 32'h0,        4'd0, 4'd0, 4'd5},  // R5 WB hit
    '{1'b0, 12'h01C, 32'h0,        2'd1, 1'b1, 32'h2222_2222, 4'd0, 4'd0, 4'd5},  // R5 data kept
    '{1'b0, 12'h11C, 32'h0,        2'd1, 1'b1, 32'hA000_0047, 4'd4, 4'd4, 4'd6},  // R6 dirty victim
    '{1'b0, 12'h01C, 32'h0,        2'd1, 1'b0, 32'h2222_2222, 4'd0, 4'd1, 4'd6},  // R6 victim landed
    '{1'b0, 12'h018, 32'h0,        2'd1, 1'b0, 32'h1111_1111, 4'd0, 4'd1, 4'd4},  // R4 memory written
    '{1'b1, 12'h024, 32'h3333_3333, 2'd1, 1'b1, 32'h0,        4'd1, 4'd0, 4'd7},  // R7 WB no-alloc miss
    '{1'b0, 12'h024, 32'h0,        2'd1, 1'b1, 32'h3333_3333, 4'd0, 4'd4, 4'd7},  // R7 still a miss
    '{1'b1, 12'h034, 32'h4444_4444, 2'd2, 1'b1, 32'h0,        4'd0, 4'd4, 4'd8},  // R8 alloc miss
    '{1'b0, 12'h034, 32'h0,        2'd1, 1'b0, 32'hA000_000D, 4'd0, 4'd1, 4'd8},  // R8 memory untouched
    '{1'b0, 12'h034, 32'h0,        2'd1, 1'b1, 32'h4444_4444, 4'd0, 4'd0, 4'd8},  // R8 merged
    '{1'b1, 12'h044, 32'h5555_5555, 2'd0, 1'b1, 32'h0,        4'd1, 4'd0, 4'd7},  // R7 WT miss
    '{1'b0, 12'h044, 32'h0,        2'd1, 1'b0, 32'h5555_5555, 4'd0, 4'd1, 4'd7},  // R7 word sent
    '{1'b0, 12'h044, 32'h0,        2'd1, 1'b1, 32'h5555_5555, 4'd0, 4'd4, 4'd7},  // R7 no alloc
    '{1'b1, 12'h030, 32'h6666_6666, 2'd1, 1'b0, 32'h0,        4'd1, 4'd0, 4'd9},  // R9 bypass write
    '{1'b0, 12'h030, 32'h0,        2'd1, 1'b1, 32'hA000_000C, 4'd0, 4'd0, 4'd9},  // R9 copy not updated
    '{1'b0, 12'h234, 32'h0,        2'd1, 1'b1, 32'hA000_008D, 4'd4, 4'd4, 4'd6},  // R6 evict merged line
    '{1'b0, 12'h034, 32'h0,        2'd1, 1'b0, 32'h4444_4444, 4'd0, 4'd1, 4'd8},  // R8 written on evict
    '{1'b0, 12'h030, 32'h0,        2'd1, 1'b0, 32'hA000_000C, 4'd0, 4'd1, 4'd6},  // R6 whole line out
    '{1'b0, 12'h100, 32'h0,        2'd1, 1'b0, 32'hA000_0040, 4'd0, 4'd1, 4'd9},  // R9 bypass read
    '{1'b0, 12'h100, 32'h0,        2'd1, 1'b1, 32'hA000_0040, 4'd0, 4'd4, 4'd9},  // R9 no alloc
    '{1'b1, 12'h0A0, 32'h8888_8888, 2'd3, 1'b1, 32'h0,        4'd0, 4'd4, 4'd1},  // R1 code 3 allocates
    '{1'b0, 12'h0A0, 32'h0,        2'd1, 1'b0, 32'hA000_0028, 4'd0, 4'd1, 4'd1}   // R1 not written through
  };

  initial begin
    logic [31:0] rd;
    int nwr, nrd, ncyc;
    rst_n = 1'b0; inv_all = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_policy = '0; req_cacheable = 1'b0;
    repeat (4) @(negedge clk);
    #2;
    chk(!req_ready && !mem_valid, "R12 in reset", {30'd0, req_ready, mem_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk(!req_ready && !mem_valid, "R12 after reset", {30'd0, req_ready, mem_valid}, 32'd0);
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      access(VECS[v].w, {20'd0, VECS[v].addr}, VECS[v].wdata, VECS[v].pol, VECS[v].cach,
             rd, nwr, nrd, ncyc);
      if (!VECS[v].w)
        chk(rd == VECS[v].exp, $sformatf("R%0d vec %0d rdata", VECS[v].req, v), rd, VECS[v].exp);
      chk(nwr == int'(VECS[v].nwr), $sformatf("R%0d vec %0d mem writes", VECS[v].req, v),
          32'(nwr), 32'(VECS[v].nwr));
      chk(nrd == int'(VECS[v].nrd), $sformatf("R%0d vec %0d mem reads", VECS[v].req, v),
          32'(nrd), 32'(VECS[v].nrd));
    end

    // R2: a hit read completes in the cycle it is presented
    access(1'b0, 32'h234, 32'h0, 2'd1, 1'b1, rd, nwr, nrd, ncyc);
    chk(ncyc == 1, "R2 hit latency", 32'(ncyc), 32'd1);

    // R10: dirty line dropped by invalidate, never written back
    access(1'b1, 32'h234, 32'h7777_7777, 2'd1, 1'b1, rd, nwr, nrd, ncyc);
    chk(nwr == 0 && ncyc == 1, "R10 setup WB hit", 32'(nwr), 32'd0);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    access(1'b0, 32'h234, 32'h0, 2'd1, 1'b1, rd, nwr, nrd, ncyc);
    chk(nwr == 0, "R10 no write-back", 32'(nwr), 32'd0);
    chk(nrd == 4, "R10 refill", 32'(nrd), 32'd4);
    chk(rd == 32'hA000_008D, "R10 stale data gone", rd, 32'hA000_008D);

    // R10: request presented with the invalidate waits that cycle
    inv_all = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h234; req_policy = 2'd1; req_cacheable = 1'b1;
    #2;
    chk(!req_ready, "R10 request waits during invalidate", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    inv_all = 1'b0;
    req_valid = 1'b0;
    access(1'b0, 32'h234, 32'h0, 2'd1, 1'b1, rd, nwr, nrd, ncyc);
    chk(nrd == 4 && rd == 32'hA000_008D, "R10 second invalidate refills", 32'(nrd), 32'd4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule